// File: doc/BRIEF.md
# Prefix-Extended Relative Branch Unit

This block works out where the program counter goes after a PC-relative jump or call whose instruction carries an 8-bit signed offset. The offset is measured from the address of the following instruction (the current PC plus one), and the sum wraps modulo 2^16. When the instruction just before the branch loaded an extension byte and raised the extension-pending flag, the offset is no longer sign-extended. Instead, the extension byte supplies the upper half of a full 16-bit signed offset. The same widening applies to the unconditional jump, to the four flag-tested jumps and to the relative call.

The decode stage presents one branch per cycle with an issue strobe, together with the current PC, the branch kind, the offset byte, the extension byte and flag, and the carry and zero flags. One clock later the unit presents a result strobe with the next PC, a taken bit, the return address, and a one-cycle push strobe when the branch is a call. The caller owns the return stack and the extension flag; this unit only reads the flag.

Top module: `relbr_unit`

## Requirements
- R1: While reset is held and for the cycles before the first issue, `res_valid`, `taken` and `push_stb` are 0, and `next_pc` and `ret_addr` are 0.
- R2: Each cycle with `issue` high produces exactly one result, with `res_valid` high on the following cycle. `res_valid`, `taken` and `push_stb` are 0 in every other cycle.
- R3: With `ext_pend` low, the offset byte is sign-extended to 16 bits. A taken branch then gives `next_pc = pc + 1 + offset`.
- R4: With `ext_pend` high, the offset is the 16-bit value {`ext_byte`, `off8`} read as two's complement. For example, ext 0x64 with offset 0x29 moves by +0x6429, ext 0xFF with 0x80 moves by -128, and ext 0x00 with 0x7F moves by +127.
- R5: Kind code 0 (plain jump) is always taken.
- R6: The kind codes are 1 = jump if carry, 2 = jump if no carry, 3 = jump if zero and 4 = jump if not zero. Each is taken only when its flag test holds, and it uses the same offset widening as the plain jump.
- R7: A branch that is not taken gives `next_pc = pc + 1`, whatever the values of `ext_pend`, `ext_byte` and `off8`.
- R8: Kind code 5 (relative call) is always taken. It raises `push_stb` for exactly the result cycle, and `ret_addr` equals `pc + 1`.
- R9: The sum of the address and the offset wraps modulo 2^16, including at PC 0xFFFF, where the following address is 0x0000.
- R10: Kind codes 6 and 7 are reserved. They are never taken, never push, and give `next_pc = pc + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | A branch is presented this cycle |
| pc | input | 16 | Address of the branch instruction |
| kind | input | 3 | Branch kind code (see R5, R6, R8, R10) |
| off8 | input | 8 | Signed offset byte from the instruction |
| ext_byte | input | 8 | Extension byte, used as the high offset byte |
| ext_pend | input | 1 | The previous instruction loaded the extension byte |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| res_valid | output | 1 | A result is presented this cycle |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | The branch was taken |
| ret_addr | output | 16 | Address of the following instruction |
| push_stb | output | 1 | Push `ret_addr` onto the return stack |

## Verification
The embedded properties check the following on every cycle:
- the push strobe only appears on a taken, valid result;
- an untaken result always lands on the return address;
- the plain jump and the call are always taken;
- results arrive exactly one cycle after an issue.

Some things only the bench scenarios can show: the exact targets for the prefixed and unprefixed offsets, each flag condition in both its true and false state, the wrap across 0xFFFF, and the handling of the reserved codes. The scoreboard compares all of these, including back-to-back issues.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

  typedef enum logic [2:0] {
    BK_JMP  = 3'd0,
    BK_JC   = 3'd1,
    BK_JNC  = 3'd2,
    BK_JZ   = 3'd3,
    BK_JNZ  = 3'd4,
    BK_CALL = 3'd5,
    BK_RSV6 = 3'd6,
    BK_RSV7 = 3'd7
  } br_kind_e;

  typedef struct packed {
    logic taken;
    logic is_call;
  } br_dec_t;

endpackage

// File: rtl/relbr_disp.sv
module relbr_disp #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter int EXT_W  = ADDR_W - OFF_W
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [EXT_W-1:0]  ext,
  input  logic              ext_en,
  output logic [ADDR_W-1:0] disp
);

  logic [EXT_W-1:0] sign_fill;
  logic [EXT_W-1:0] high_part;

  // Replicate the offset sign across the upper part
  always_comb begin
    sign_fill = {EXT_W{off[OFF_W-1]}};
  end

  // Pick prefix byte or sign fill for the upper part
  always_comb begin
    if (ext_en) begin
      high_part = ext;
    end else begin
      high_part = sign_fill;
    end
  end

  always_comb begin
    disp = {high_part, off};
  end

endmodule

// File: rtl/relbr_cond.sv
module relbr_cond
  import relbr_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       flag_c,
  input  logic       flag_z,
  output br_dec_t    dec
);

  br_kind_e k;

  always_comb begin
    k = br_kind_e'(kind);
  end

  always_comb begin
    dec.taken   = 1'b0;
    dec.is_call = 1'b0;
    unique case (k)
      BK_JMP:  dec.taken = 1'b1;
      BK_JC:   dec.taken = flag_c;
      BK_JNC:  dec.taken = ~flag_c;
      BK_JZ:   dec.taken = flag_z;
      BK_JNZ:  dec.taken = ~flag_z;
      BK_CALL: begin
        dec.taken   = 1'b1;
        dec.is_call = 1'b1;
      end
      BK_RSV6, BK_RSV7: dec.taken = 1'b0;
      default: dec.taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/relbr_target.sv
module relbr_target #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] jump_addr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  always_comb begin
    seq_addr = pc + STEP;
  end

  always_comb begin
    jump_addr = seq_addr + disp;
  end

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
  import relbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] pc,
  input  logic [2:0]        kind,
  input  logic [OFF_W-1:0]  off8,
  input  logic [ADDR_W-OFF_W-1:0] ext_byte,
  input  logic              ext_pend,
  input  logic              flag_c,
  input  logic              flag_z,
  output logic              res_valid,
  output logic [ADDR_W-1:0] next_pc,
  output logic              taken,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              push_stb
);

  localparam int EXT_W = ADDR_W - OFF_W;

  // Reset release synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  always_comb begin
    rst_int_n = rst_pipe_q[SYNC_STAGES-1];
  end

  // Datapath pieces
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] jump_addr;
  br_dec_t           dec;

  relbr_disp #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .EXT_W  (EXT_W)
  ) u_disp (
    .off    (off8),
    .ext    (ext_byte),
    .ext_en (ext_pend),
    .disp   (disp)
  );

  relbr_cond u_cond (
    .kind   (kind),
    .flag_c (flag_c),
    .flag_z (flag_z),
    .dec    (dec)
  );

  relbr_target #(
    .ADDR_W (ADDR_W)
  ) u_target (
    .pc        (pc),
    .disp      (disp),
    .seq_addr  (seq_addr),
    .jump_addr (jump_addr)
  );

  // Next-state logic
  logic              valid_d, taken_d, push_d;
  logic [ADDR_W-1:0] npc_d, ret_d;
  logic              data_en;

  always_comb begin
    data_en = issue;
    valid_d = issue;
    taken_d = issue & dec.taken;
    push_d  = issue & dec.is_call;
    ret_d   = seq_addr;
    if (dec.taken) begin
      npc_d = jump_addr;
    end else begin
      npc_d = seq_addr;
    end
  end

  // Registers
  logic              valid_q, taken_q, push_q;
  logic [ADDR_W-1:0] npc_q, ret_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      push_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
      push_q  <= push_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      npc_q <= '0;
      ret_q <= '0;
    end else if (data_en) begin
      npc_q <= npc_d;
      ret_q <= ret_d;
    end
  end

  always_comb begin
    res_valid = valid_q;
    taken     = taken_q;
    push_stb  = push_q;
    next_pc   = npc_q;
    ret_addr  = ret_q;
  end

  // Embedded checks
  assert_push_needs_taken_R8: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    push_stb |-> (taken && res_valid)
  ) else $error("push without taken result");

  assert_untaken_falls_through_R7: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    (res_valid && !taken) |-> (next_pc == ret_addr)
  ) else $error("untaken result not at following address");

  assert_result_follows_issue_R2: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    issue |=> res_valid
  ) else $error("result missing after issue");

  assert_no_spurious_result_R2: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    !issue |=> !res_valid
  ) else $error("result without issue");

  assert_jump_always_taken_R5: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    (issue && kind == 3'd0) |=> taken
  ) else $error("plain jump not taken");

  assert_call_pushes_R8: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    (issue && kind == 3'd5) |=> (taken && push_stb)
  ) else $error("call did not push");

  assert_ret_is_following_R8: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    issue |=> (ret_addr == $past(pc) + ADDR_W'(1))
  ) else $error("return address wrong");

  assert_reserved_idle_R10: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    (issue && kind[2:1] == 2'b11) |=> (!taken && !push_stb)
  ) else $error("reserved kind acted");

endmodule

// File: tb/relbr_unit_test.sv
module relbr_unit_test;

  logic        clk;
  logic        rst_n;
  logic        issue;
  logic [15:0] pc;
  logic [2:0]  kind;
  logic [7:0]  off8;
  logic [7:0]  ext_byte;
  logic        ext_pend;
  logic        flag_c;
  logic        flag_z;
  logic        res_valid;
  logic [15:0] next_pc;
  logic        taken;
  logic [15:0] ret_addr;
  logic        push_stb;

  relbr_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .pc        (pc),
    .kind      (kind),
    .off8      (off8),
    .ext_byte  (ext_byte),
    .ext_pend  (ext_pend),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .res_valid (res_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .ret_addr  (ret_addr),
    .push_stb  (push_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [15:0] npc;
    logic        tk;
    logic        psh;
    logic [15:0] ret;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  bit   mon_on = 1'b0;
  bit   done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Reference model built from the requirement text
  function automatic exp_t model(input logic [15:0] p, input logic [2:0] k,
                                 input logic [7:0] o, input logic [7:0] e,
                                 input logic ep, input logic c, input logic z,
                                 input string tag);
    exp_t r;
    logic [15:0] d;
    logic        t;
    d = ep ? {e, o} : {{8{o[7]}}, o};
    case (k)
      3'd0: t = 1'b1;
      3'd1: t = c;
      3'd2: t = !c;
      3'd3: t = z;
      3'd4: t = !z;
      3'd5: t = 1'b1;
      default: t = 1'b0;
    endcase
    r.ret = p + 16'd1;
    r.npc = t ? (p + 16'd1 + d) : (p + 16'd1);
    r.tk  = t;
    r.psh = (k == 3'd5);
    r.due = 0;
    r.tag = tag;
    return r;
  endfunction

  task automatic drive(input logic [15:0] p, input logic [2:0] k,
                       input logic [7:0] o, input logic [7:0] e,
                       input logic ep, input logic c, input logic z,
                       input string tag);
    exp_t x;
    @(negedge clk);
    issue = 1'b1; pc = p; kind = k; off8 = o; ext_byte = e;
    ext_pend = ep; flag_c = c; flag_z = z;
    x = model(p, k, o, e, ep, c, z, tag);
    x.due = cyc + 1;
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue = 1'b0;
      pc = 16'hDEAD; kind = 3'd0; off8 = 8'h55; ext_byte = 8'hAA;
      ext_pend = 1'b1;
    end
  endtask

  // Monitor: compare results against the queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t x;
        x = q.pop_front();
        check(res_valid === 1'b1, {x.tag, "/R2"}, "res_valid", 16'(res_valid), 16'd1);
        check(next_pc === x.npc, x.tag, "next_pc", next_pc, x.npc);
        check(taken === x.tk, x.tag, "taken", 16'(taken), 16'(x.tk));
        check(push_stb === x.psh, {x.tag, "/R8"}, "push_stb", 16'(push_stb), 16'(x.psh));
        check(ret_addr === x.ret, {x.tag, "/R8"}, "ret_addr", ret_addr, x.ret);
      end else if (res_valid !== 1'b0 || push_stb !== 1'b0 || taken !== 1'b0) begin
        check(1'b0, "R2", "idle strobes", {13'd0, res_valid, taken, push_stb}, 16'd0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    issue = 1'b0; pc = '0; kind = '0; off8 = '0; ext_byte = '0;
    ext_pend = 1'b0; flag_c = 1'b0; flag_z = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(res_valid === 1'b0 && taken === 1'b0 && push_stb === 1'b0, "R1",
          "strobes in reset", {13'd0, res_valid, taken, push_stb}, 16'd0);
    check(next_pc === 16'd0 && ret_addr === 16'd0, "R1", "addr in reset",
          next_pc | ret_addr, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_valid === 1'b0 && next_pc === 16'd0, "R1", "after release",
          next_pc, 16'd0);
    mon_on = 1'b1;

    // R3 unprefixed forward/backward
    drive(16'h1000, 3'd0, 8'h29, 8'h64, 1'b0, 1'b0, 1'b0, "R3_fwd");
    drive(16'h1000, 3'd0, 8'h88, 8'h3A, 1'b0, 1'b0, 1'b0, "R3_back");
    idle(2);
    // R4 prefixed examples
    drive(16'h1000, 3'd0, 8'h29, 8'h64, 1'b1, 1'b0, 1'b0, "R4_6429");
    drive(16'h1000, 3'd0, 8'h7F, 8'h00, 1'b1, 1'b0, 1'b0, "R4_p127");
    drive(16'h1000, 3'd0, 8'h80, 8'hFF, 1'b1, 1'b0, 1'b0, "R4_m128");
    drive(16'h2000, 3'd0, 8'h7F, 8'h80, 1'b1, 1'b0, 1'b0, "R4_neg_hi");
    idle(1);
    // R5 plain jump taken regardless of flags
    drive(16'h0300, 3'd0, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, "R5_flags");
    // R6 conditions, both polarities, with prefix 0x3A88
    for (int c = 0; c < 2; c++) begin
      for (int z = 0; z < 2; z++) begin
        drive(16'h1000, 3'd1, 8'h88, 8'h3A, 1'b1, 1'(c), 1'(z), "R6_jc");
        drive(16'h1000, 3'd2, 8'h88, 8'h3A, 1'b1, 1'(c), 1'(z), "R6_jnc");
        drive(16'h1000, 3'd3, 8'h88, 8'h3A, 1'b1, 1'(c), 1'(z), "R6_jz");
        drive(16'h1000, 3'd4, 8'h88, 8'h3A, 1'b1, 1'(c), 1'(z), "R6_jnz");
      end
    end
    idle(1);
    // R7 not taken ignores prefix and offset
    drive(16'h4444, 3'd4, 8'h7F, 8'h7F, 1'b1, 1'b0, 1'b1, "R7_pref");
    drive(16'h4444, 3'd1, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0, "R7_nopref");
    idle(1);
    // R8 call, prefixed and plain
    drive(16'h1000, 3'd5, 8'h62, 8'hF8, 1'b1, 1'b0, 1'b0, "R8_f862");
    idle(1);
    drive(16'h0500, 3'd5, 8'hF0, 8'h00, 1'b0, 1'b1, 1'b0, "R8_plain");
    drive(16'h0600, 3'd5, 8'h04, 8'h00, 1'b0, 1'b0, 1'b1, "R8_b2b");
    idle(2);
    // R9 wrap
    drive(16'hFFF0, 3'd0, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0, "R9_up");
    drive(16'hFFFF, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R9_ffff");
    drive(16'h0002, 3'd0, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b0, "R9_down");
    drive(16'hFFFF, 3'd5, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, "R9_callret");
    idle(1);
    // R10 reserved codes
    drive(16'h0700, 3'd6, 8'h40, 8'h12, 1'b1, 1'b1, 1'b1, "R10_k6");
    drive(16'h0700, 3'd7, 8'h40, 8'h12, 1'b0, 1'b0, 1'b0, "R10_k7");
    idle(4);

    check(q.size() == 0, "R2", "results outstanding", 16'(q.size()), 16'd0);
    finish_run();
  end

endmodule